// File: doc/BRIEF.md
# Dispatch Stage Stall Controller with Skid Buffer

This block governs the flow of instruction groups from an upstream rename stage into an issue queue. It keeps a five-state status (Idle, Running, Blocked, Unblocking, Squashing). While the path ahead is open, it passes each incoming group straight through in the same cycle. When the downstream stage stalls, or the issue queue is full, it blocks. From that point it captures every valid incoming group in a small FIFO of whole groups and holds a stall signal back to the upstream stage.

When the stall causes clear, the controller replays the captured groups in arrival order, one per cycle. It keeps the upstream stall raised until the last captured group has left, and only then returns to Running. A squash request from commit, or a reorder-buffer squash in progress, overrides any blocking. It discards every captured group in one cycle and holds the stage in Squashing until both squash inputs are low. A push into a full buffer drops the group and raises a sticky error flag.

Top module: `stage_stall_ctrl`

## Requirements
- R1: After reset the status is Idle and `up_stall`, `disp_valid`, `squashing` and `skid_overflow` are all 0.
- R2: In Idle or Running, with no squash input, `dn_stall` low and `iq_full` low, a valid upstream group is dispatched in the same cycle: `disp_valid` equals `up_valid`, `disp_group` equals `up_group`, and `up_stall` is 0.
- R3: In Idle or Running, `dn_stall` high blocks the stage. No group is dispatched, a valid group present that cycle is captured, and `up_stall` is 1 from the next cycle.
- R4: In Idle or Running, a valid group that arrives while `iq_full` is high is not dispatched. It is captured, and the stage blocks as in R3.
- R5: While Blocked, `up_stall` stays 1, no group is dispatched, and every valid incoming group is captured. The stage moves to Unblocking only after a cycle in which `dn_stall` and `iq_full` are both low.
- R6: In Unblocking, the captured groups are dispatched one per cycle in arrival order, with `disp_valid` set and `up_stall` held at 1. The cycle after the last one leaves, the stage is Running and `up_stall` is 0.
- R7: Entering Squashing empties the skid buffer. No group captured before the squash is ever dispatched afterwards, and `disp_valid` is 0 while `squashing` is 1.
- R8: The stage leaves Squashing for Running only after a cycle in which `cmt_squash` and `rob_squashing` are both low. Until then `squashing` and `up_stall` stay 1.
- R9: A capture into a buffer that already holds SKID_DEPTH groups (4 by default) drops that group and sets `skid_overflow`, which stays 1 until reset. The groups already held are still replayed in order.
- R10: A high `cmt_squash` or `rob_squashing` in Idle, Running, Blocked or Unblocking moves the stage to Squashing on the next cycle, even when `dn_stall` or `iq_full` is also high. No group is dispatched in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream group present this cycle |
| up_group | input | GRP_W | Upstream group payload |
| dn_stall | input | 1 | Stall request from the downstream stage |
| cmt_squash | input | 1 | Squash request from commit |
| rob_squashing | input | 1 | Reorder buffer is still squashing |
| iq_full | input | 1 | Issue queue has no room |
| up_stall | output | 1 | Stall back to the upstream stage |
| disp_valid | output | 1 | A group is dispatched this cycle |
| disp_group | output | GRP_W | Dispatched group payload |
| squashing | output | 1 | Stage is in Squashing |
| skid_overflow | output | 1 | Sticky: a captured group was dropped |

## Verification
A wrong status shows at the ports within one cycle. A missed block lets a group through while `dn_stall` is high. A stuck Blocked state holds `up_stall` after the stall causes have cleared. An early exit from Squashing drops `squashing` while a squash input is still high. A buffer-pointer or count error shows only when the buffer is replayed. That can be a few cycles after the capture: a lost, duplicated, reordered or stale group on `disp_group`, or `up_stall` falling one cycle early or late. The directed scenarios therefore always follow a capture with a full replay and compare every replayed payload.

// File: rtl/stall_ctrl_pkg.sv
package stall_ctrl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RUN     = 3'd1,
      ST_BLOCKED = 3'd2,
      ST_UNBLOCK = 3'd3,
      ST_SQUASH  = 3'd4
   } stage_state_e;
endpackage

// File: rtl/group_skid_fifo.sv
module group_skid_fifo #(
   parameter int GRP_W = 32,
   parameter int DEPTH = 4,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   input  logic [GRP_W-1:0] wdata,
   output logic [GRP_W-1:0] head,
   output logic             empty,
   output logic             full,
   output logic [CW-1:0]    count,
   output logic             ovf_sticky
);
   localparam bit IS_POW2 = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

   logic [GRP_W-1:0] mem [DEPTH];
   logic [PW-1:0]    rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic             do_push, do_pop, drop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop && !empty && !flush;
   assign do_push = push && !flush && (!full || do_pop);
   assign drop    = push && !flush && full && !do_pop;
   assign head    = mem[rd_ptr];

   generate
      if (IS_POW2) begin : g_wrap_natural
         assign rd_nxt = rd_ptr + PW'(1);
         assign wr_nxt = wr_ptr + PW'(1);
      end else begin : g_wrap_compare
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr     <= '0;
         wr_ptr     <= '0;
         count      <= '0;
         ovf_sticky <= 1'b0;
      end else begin
         if (drop) ovf_sticky <= 1'b1;
         if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
         end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
            case ({do_push, do_pop})
               2'b10:   count <= count + CW'(1);
               2'b01:   count <= count - CW'(1);
               default: count <= count;
            endcase
         end
      end
   end
endmodule

// File: rtl/stage_status_fsm.sv
module stage_status_fsm
   import stall_ctrl_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up_valid,
   input  logic         dn_stall,
   input  logic         cmt_squash,
   input  logic         rob_squashing,
   input  logic         iq_full,
   input  logic         skid_empty,
   input  logic [CW-1:0] skid_count,
   output logic         push,
   output logic         pop,
   output logic         flush,
   output logic         disp_valid,
   output logic         disp_from_skid,
   output logic         up_stall,
   output logic         squashing
);
   stage_state_e st, nxt;
   logic         sq_req;

   assign sq_req = cmt_squash | rob_squashing;

   always_comb begin
      nxt            = st;
      push           = 1'b0;
      pop            = 1'b0;
      flush          = 1'b0;
      disp_valid     = 1'b0;
      disp_from_skid = 1'b0;
      unique case (st)
         ST_IDLE, ST_RUN: begin
            if (sq_req) begin
               nxt   = ST_SQUASH;
               flush = 1'b1;
            end else if (dn_stall || (up_valid && iq_full)) begin
               nxt  = ST_BLOCKED;
               push = up_valid;
            end else if (up_valid) begin
               nxt        = ST_RUN;
               disp_valid = 1'b1;
            end
         end
         ST_BLOCKED: begin
            if (sq_req) begin
               nxt   = ST_SQUASH;
               flush = 1'b1;
            end else begin
               push = up_valid;
               if (!dn_stall && !iq_full) nxt = ST_UNBLOCK;
            end
         end
         ST_UNBLOCK: begin
            if (sq_req) begin
               nxt   = ST_SQUASH;
               flush = 1'b1;
            end else if (dn_stall || iq_full) begin
               nxt  = ST_BLOCKED;
               push = up_valid;
            end else begin
               push           = up_valid;
               pop            = !skid_empty;
               disp_valid     = !skid_empty;
               disp_from_skid = 1'b1;
               if (!up_valid && (skid_empty || skid_count == CW'(1)))
                  nxt = ST_RUN;
            end
         end
         ST_SQUASH: begin
            flush = 1'b1;
            if (!sq_req) nxt = ST_RUN;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nxt;
   end

   assign up_stall  = (st == ST_BLOCKED) || (st == ST_UNBLOCK) || (st == ST_SQUASH);
   assign squashing = (st == ST_SQUASH);
endmodule

// File: rtl/stage_stall_ctrl.sv
module stage_stall_ctrl #(
   parameter int GRP_W      = 32,
   parameter int SKID_DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_valid,
   input  logic [GRP_W-1:0] up_group,
   input  logic             dn_stall,
   input  logic             cmt_squash,
   input  logic             rob_squashing,
   input  logic             iq_full,
   output logic             up_stall,
   output logic             disp_valid,
   output logic [GRP_W-1:0] disp_group,
   output logic             squashing,
   output logic             skid_overflow
);
   localparam int CW = $clog2(SKID_DEPTH + 1);

   generate
      if (GRP_W < 1) begin : g_bad_width
         $error("stage_stall_ctrl: GRP_W must be at least 1");
      end
      if (SKID_DEPTH < 1) begin : g_bad_depth
         $error("stage_stall_ctrl: SKID_DEPTH must be at least 1");
      end
   endgenerate

   logic             push, pop, flush, from_skid, sk_empty, sk_full;
   logic [CW-1:0]    sk_count;
   logic [GRP_W-1:0] sk_head;

   group_skid_fifo #(.GRP_W(GRP_W), .DEPTH(SKID_DEPTH)) u_skid (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .pop        (pop),
      .flush      (flush),
      .wdata      (up_group),
      .head       (sk_head),
      .empty      (sk_empty),
      .full       (sk_full),
      .count      (sk_count),
      .ovf_sticky (skid_overflow)
   );

   stage_status_fsm #(.DEPTH(SKID_DEPTH)) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .up_valid       (up_valid),
      .dn_stall       (dn_stall),
      .cmt_squash     (cmt_squash),
      .rob_squashing  (rob_squashing),
      .iq_full        (iq_full),
      .skid_empty     (sk_empty),
      .skid_count     (sk_count),
      .push           (push),
      .pop            (pop),
      .flush          (flush),
      .disp_valid     (disp_valid),
      .disp_from_skid (from_skid),
      .up_stall       (up_stall),
      .squashing      (squashing)
   );

   assign disp_group = from_skid ? sk_head : up_group;

   logic unused_full;
   assign unused_full = sk_full;
endmodule

// File: rtl/stage_stall_chk.sv
module stage_stall_chk #(
   parameter int GRP_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             up_valid,
   input logic [GRP_W-1:0] up_group,
   input logic             dn_stall,
   input logic             cmt_squash,
   input logic             rob_squashing,
   input logic             iq_full,
   input logic             up_stall,
   input logic             disp_valid,
   input logic [GRP_W-1:0] disp_group,
   input logic             squashing,
   input logic             skid_overflow
);
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !up_stall) |-> (up_valid && disp_group == up_group)); // R2
   AST_NO_DISP_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      dn_stall |-> !disp_valid); // R3
   AST_NO_DISP_IQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_stall && iq_full) |-> !disp_valid); // R4
   AST_NO_DISP_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
      squashing |-> !disp_valid); // R7
   AST_SQUASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (squashing && (cmt_squash || rob_squashing)) |=> (squashing && up_stall)); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      skid_overflow |=> skid_overflow); // R9
   AST_SQUASH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_squash || rob_squashing) |=> squashing); // R10
endmodule

bind stage_stall_ctrl stage_stall_chk #(.GRP_W(GRP_W)) u_stall_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .up_valid      (up_valid),
   .up_group      (up_group),
   .dn_stall      (dn_stall),
   .cmt_squash    (cmt_squash),
   .rob_squashing (rob_squashing),
   .iq_full       (iq_full),
   .up_stall      (up_stall),
   .disp_valid    (disp_valid),
   .disp_group    (disp_group),
   .squashing     (squashing),
   .skid_overflow (skid_overflow)
);

// File: tb/sim_stage_stall_ctrl.sv
`timescale 1ns/1ps
module sim_stage_stall_ctrl;
   localparam int GW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          up_valid = 1'b0;
   logic [GW-1:0] up_group = '0;
   logic          dn_stall = 1'b0;
   logic          cmt_squash = 1'b0;
   logic          rob_squashing = 1'b0;
   logic          iq_full = 1'b0;
   logic          up_stall, disp_valid, squashing, skid_overflow;
   logic [GW-1:0] disp_group;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   stage_stall_ctrl #(.GRP_W(GW), .SKID_DEPTH(4)) u0 (
      .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_group(up_group),
      .dn_stall(dn_stall), .cmt_squash(cmt_squash), .rob_squashing(rob_squashing),
      .iq_full(iq_full), .up_stall(up_stall), .disp_valid(disp_valid),
      .disp_group(disp_group), .squashing(squashing), .skid_overflow(skid_overflow)
   );

   task automatic chk(input string req, input string what,
                      input logic [GW-1:0] act, input logic [GW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [GW-1:0] g, input logic ds,
                       input logic sq, input logic rs, input logic iqf);
      @(negedge clk);
      up_valid = v; up_group = g; dn_stall = ds;
      cmt_squash = sq; rob_squashing = rs; iq_full = iqf;
      #2;
   endtask

   task automatic expect_out(input string req, input logic st, input logic dv,
                             input logic [GW-1:0] grp);
      chk(req, "up_stall", {31'd0, up_stall}, {31'd0, st});
      chk(req, "disp_valid", {31'd0, disp_valid}, {31'd0, dv});
      if (dv) chk(req, "disp_group", disp_group, grp);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) step(0, 0, 0, 0, 0, 0);
      chk("R1", "up_stall", {31'd0, up_stall}, 0);
      chk("R1", "disp_valid", {31'd0, disp_valid}, 0);
      chk("R1", "squashing", {31'd0, squashing}, 0);
      chk("R1", "skid_overflow", {31'd0, skid_overflow}, 0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_run;
      step(1, 32'hA1, 0, 0, 0, 0); expect_out("R2", 0, 1, 32'hA1);
      step(1, 32'hA2, 0, 0, 0, 0); expect_out("R2", 0, 1, 32'hA2);
      step(0, 32'h0,  0, 0, 0, 0); expect_out("R2", 0, 0, 0);
   endtask

   task automatic t_block;
      step(1, 32'hB0, 1, 0, 0, 0); expect_out("R3", 0, 0, 0);
      step(1, 32'hB1, 1, 0, 0, 0); expect_out("R3", 1, 0, 0);
      step(0, 0, 0, 0, 0, 1);      expect_out("R5", 1, 0, 0);
      step(0, 0, 0, 0, 0, 0);      expect_out("R5", 1, 0, 0);
      step(0, 0, 0, 0, 0, 0);      expect_out("R6", 1, 1, 32'hB0);
      step(0, 0, 0, 0, 0, 0);      expect_out("R6", 1, 1, 32'hB1);
      step(0, 0, 0, 0, 0, 0);      expect_out("R6", 0, 0, 0);
      step(1, 32'hB2, 0, 0, 0, 0); expect_out("R6", 0, 1, 32'hB2);
   endtask

   task automatic t_iqfull;
      step(1, 32'hC0, 0, 0, 0, 1); expect_out("R4", 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);      expect_out("R4", 1, 0, 0);
      step(0, 0, 0, 0, 0, 0);      expect_out("R4", 1, 1, 32'hC0);
      step(0, 0, 0, 0, 0, 0);      expect_out("R4", 0, 0, 0);
   endtask

   task automatic t_squash_blocked;
      step(1, 32'hE0, 1, 0, 0, 0); expect_out("R3", 0, 0, 0);
      step(1, 32'hE1, 1, 1, 0, 0); expect_out("R10", 1, 0, 0);
      step(0, 0, 0, 0, 1, 0);
      chk("R10", "squashing", {31'd0, squashing}, 1);
      expect_out("R8", 1, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      chk("R8", "squashing", {31'd0, squashing}, 1);
      step(0, 0, 1, 0, 0, 0);
      chk("R8", "squashing", {31'd0, squashing}, 0);
      expect_out("R8", 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);      expect_out("R7", 1, 0, 0);
      step(0, 0, 0, 0, 0, 0);      expect_out("R7", 1, 0, 0);
      step(0, 0, 0, 0, 0, 0);      expect_out("R7", 0, 0, 0);
   endtask

   task automatic t_squash_run;
      step(1, 32'hF0, 1, 1, 0, 0); expect_out("R10", 0, 0, 0);
      step(1, 32'hF1, 0, 0, 0, 0);
      chk("R10", "squashing", {31'd0, squashing}, 1);
      expect_out("R7", 1, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      chk("R8", "squashing", {31'd0, squashing}, 0);
      expect_out("R8", 0, 0, 0);
   endtask

   task automatic t_overflow;
      for (int i = 0; i < 5; i++) step(1, 32'hD0 + i, 1, 0, 0, 0);
      chk("R9", "skid_overflow before drop", {31'd0, skid_overflow}, 0);
      step(0, 0, 1, 0, 0, 0);
      chk("R9", "skid_overflow", {31'd0, skid_overflow}, 1);
      step(0, 0, 0, 0, 0, 0);      expect_out("R9", 1, 0, 0);
      for (int i = 0; i < 4; i++) begin
         step(0, 0, 0, 0, 0, 0);   expect_out("R9", 1, 1, 32'hD0 + i);
      end
      step(0, 0, 0, 0, 0, 0);      expect_out("R9", 0, 0, 0);
      chk("R9", "skid_overflow sticky", {31'd0, skid_overflow}, 1);
   endtask

   initial begin
      t_reset;
      t_run;
      t_block;
      t_iqfull;
      t_squash_blocked;
      t_squash_run;
      t_overflow;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired before the scenarios completed");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule